// File: doc/BRIEF.md
# Register-Mapped Random Word Generator

This block is a random-word peripheral on a small 32-bit register bus with a setup phase and an access phase. A bit source produces a stream of bits on generation ticks; a packer groups the bits into 32-bit words and pushes them into a small output queue, and software pops the words by reading the data register. The physical noise source is replaced by a 32-bit shift-register sequence whose output is mixed with the enabled lanes of two six-lane oscillator groups, so every word can be predicted.

Software sets a warm-up count through the status register, picks the tick rate (one tick per bus cycle, or a slow tick taken from the bus clock divided by an even factor) and the speed (one or two bits per tick), then sets the enable bit. Bits produced while the warm-up count is non-zero are thrown away. An interrupt line reports that the queue holds at least a programmable number of words.

Top module: `rng_periph`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x0004_0000 (warm-up 0x40000, no words), the threshold register reads 4, the interrupt-off register reads 0 and irq_o is low.
- R2: Register offsets are control 0x00, status 0x04, data 0x08, threshold 0x0C, interrupt-off 0x10. Control keeps bits 0, 1, 4, 5, 15:8 and 27:16 and reads the rest as 0; threshold keeps bits 4:0; interrupt-off keeps bit 0; other offsets read 0.
- R3: The sequence register s starts at the SEED parameter and steps to {s[30:0], f} with f = s[31]^s[21]^s[1]^s[0]. Each bit taken from state s is f ^ parity(~A & s[5:0]) ^ parity(~B & s[11:6]), where A is control 21:16 and B is control 27:22 (a 0 mask bit enables a lane). The first bit of a word lands in bit 31.
- R4: With control bit 0 set, a tick happens every bus cycle, except when bits 4 and 5 are both set, where a tick happens every 2*(N+1) cycles with N the control field 15:8; the first word is counted 32 ticks after enabling from an empty state.
- R5: Control bit 1 makes each tick take two consecutive bits of the same stream, so a word needs 16 ticks.
- R6: Writing the status register loads bits 19:0 into the warm-up count, read back in status bits 19:0; while it is non-zero each tick discards its bits and lowers the count by the number of bits, stopping at 0.
- R7: Status bits 31:24 give the number of words in the queue.
- R8: A read of the data register returns the oldest word and removes it.
- R9: A data read on an empty queue returns 0 and the count stays 0.
- R10: When the queue is full no tick happens and the sequence holds, so no bit is lost.
- R11: Clearing control bit 0 stops ticks and keeps both the queued words and the partial word.
- R12: irq_o is high exactly when the word count is at or above the threshold and interrupt-off bit 0 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 5 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| irq_o | output | 1 | Words-available interrupt |

## Verification
The assertions assume that the double-speed bit is changed only while no word is partly assembled, and that bus transfers follow the two-phase order with at most one access per cycle. The stimulus keeps to this by altering control only after the queue is full, when the packer holds no partial word. They also take the divider and enable fields as steady between register writes, which holds because only bus writes change them.

// File: rtl/rng_pkg.sv
// Package: shared constants and types of the random word generator.
// Assumes a 32-bit data bus and byte offsets on a 5-bit address.
package rng_pkg;
    localparam int WORD_W  = 32;
    localparam int OSC_N   = 6;
    localparam int DIV_W   = 8;
    localparam int WARM_W  = 20;
    localparam int THR_W   = 5;
    localparam int ADDR_W  = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_DATA = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_THR  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_IOFF = 5'h10;

    // Writable control bits; everything else reads as zero.
    localparam logic [WORD_W-1:0] CTRL_KEEP = 32'h0FFF_FF33;

    typedef struct packed {
        logic [OSC_N-1:0] osc_b;
        logic [OSC_N-1:0] osc_a;
        logic [DIV_W-1:0] div_n;
        logic             slow_src;
        logic             slow_sel;
        logic             dbl;
        logic             run;
    } ctrl_t;
endpackage

// File: rtl/rng_tick_gen.sv
// Tick generator: one tick per cycle, or one every 2*(N+1) cycles in slow
// mode. Assumes div_n and slow_mode change only through register writes.
module rng_tick_gen
    import rng_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          slow_mode,
    input  logic [DW-1:0] div_n,
    input  logic          stall,
    output logic          tick_o
);
    localparam int CW = DW + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit  = {div_n, 1'b1};
    assign tick_o = run && !stall && (!slow_mode || (cnt_q == limit));

    // Count bus cycles within one slow period; hold while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || !slow_mode) begin
            cnt_q <= '0;
        end else if (!stall) begin
            cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
        end
    end

    AST_SLOW_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_mode && tick_o) |=> (!tick_o || !slow_mode))
        else $error("slow ticks back to back"); // R4
endmodule

// File: rtl/rng_bit_src.sv
// Bit source stub: a 32-bit shift-register sequence mixed with the enabled
// oscillator lanes. Steps once or twice per tick; holds otherwise.
module rng_bit_src
    import rng_pkg::*;
#(
    parameter logic [WORD_W-1:0] SEED = 32'h1ACE_B00C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             dbl,
    input  logic [OSC_N-1:0] osc_a,
    input  logic [OSC_N-1:0] osc_b,
    output logic             bit0_o,
    output logic             bit1_o
);
    logic [WORD_W-1:0] seq_q;
    logic [WORD_W-1:0] seq1;
    logic [WORD_W-1:0] seq2;

    function automatic logic [WORD_W-1:0] advance(input logic [WORD_W-1:0] s);
        return {s[WORD_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic mix(input logic [WORD_W-1:0] s,
                                 input logic [OSC_N-1:0] ma,
                                 input logic [OSC_N-1:0] mb);
        return (s[31] ^ s[21] ^ s[1] ^ s[0])
             ^ (^(~ma & s[OSC_N-1:0]))
             ^ (^(~mb & s[2*OSC_N-1:OSC_N]));
    endfunction

    // Next states and the two candidate bits of this tick.
    always_comb begin
        seq1   = advance(seq_q);
        seq2   = advance(seq1);
        bit0_o = mix(seq_q, osc_a, osc_b);
        bit1_o = mix(seq1, osc_a, osc_b);
    end

    // Step the sequence on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SEED;
        end else if (tick) begin
            seq_q <= dbl ? seq2 : seq1;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(seq_q))
        else $error("sequence moved without tick"); // R11
endmodule

// File: rtl/rng_word_pack.sv
// Word packer: runs the warm-up countdown, then shifts bits into a word
// (first bit ends in the MSB) and pushes each complete word.
// Assumes the speed bit changes only at word boundaries.
module rng_word_pack
    import rng_pkg::*;
#(
    parameter logic [WARM_W-1:0] WARM_INIT = 20'h40000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              dbl,
    input  logic              bit0,
    input  logic              bit1,
    input  logic              warm_load,
    input  logic [WARM_W-1:0] warm_val,
    output logic [WARM_W-1:0] warm_o,
    output logic              push_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int FW = $clog2(WORD_W + 2);

    logic [WARM_W-1:0] warm_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_n;
    logic [FW-1:0]     fill_q;
    logic [FW-1:0]     fill_n;
    logic [WARM_W-1:0] nbits;
    logic              take;

    // Next word contents and fill level for this tick.
    always_comb begin
        nbits = dbl ? WARM_W'(2) : WARM_W'(1);
        if (dbl) begin
            acc_n  = {acc_q[WORD_W-3:0], bit0, bit1};
            fill_n = fill_q + FW'(2);
        end else begin
            acc_n  = {acc_q[WORD_W-2:0], bit0};
            fill_n = fill_q + FW'(1);
        end
        take   = tick && (warm_q == '0);
        push_o = take && (fill_n >= FW'(WORD_W));
    end

    assign word_o = acc_n;
    assign warm_o = warm_q;

    // Warm-up countdown and word assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= WARM_INIT;
            acc_q  <= '0;
            fill_q <= '0;
        end else begin
            if (warm_load) begin
                warm_q <= warm_val;
            end else if (tick && (warm_q != '0)) begin
                warm_q <= (warm_q > nbits) ? warm_q - nbits : '0;
            end
            if (take) begin
                acc_q  <= acc_n;
                fill_q <= push_o ? fill_n - FW'(WORD_W) : fill_n;
            end
        end
    end

    AST_WARM_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q != '0) |=> $stable(fill_q))
        else $error("bit kept during warm-up"); // R6
endmodule

// File: rtl/rng_fifo.sv
// Word queue: DEPTH entries, oldest word on data_o, zero when empty.
// Assumes the writer never pushes while full.
module rng_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] data_o,
    output logic [CW-1:0]    count_o,
    output logic             full_o,
    output logic             empty_o
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp_q;
    logic [AW-1:0]    rp_q;
    logic [CW-1:0]    count_q;
    logic             do_push;
    logic             do_pop;

    assign full_o  = (count_q == CW'(DEPTH));
    assign empty_o = (count_q == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign data_o  = empty_o ? '0 : mem[rp_q];
    assign count_o = count_q;

    // Store pushed words.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp_q] <= data_i;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q    <= '0;
            rp_q    <= '0;
            count_q <= '0;
        end else begin
            if (do_push) begin
                wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            end
            if (do_pop) begin
                rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            end
            if (do_push && !do_pop) begin
                count_q <= count_q + 1'b1;
            end else if (do_pop && !do_push) begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o)
        else $error("push into full queue"); // R10
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> (count_q == '0))
        else $error("count moved on empty pop"); // R9
endmodule

// File: rtl/rng_periph.sv
// Top: register file on a two-phase 32-bit bus, tick generator, bit
// source, word packer and queue. Assumes one access per transfer and
// DEPTH below 256 so the count fits the status byte.
module rng_periph
    import rng_pkg::*;
#(
    parameter int                DEPTH     = 8,
    parameter logic [WORD_W-1:0] SEED      = 32'h1ACE_B00C,
    parameter logic [WARM_W-1:0] WARM_INIT = 20'h40000,
    parameter logic [THR_W-1:0]  THR_INIT  = 5'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [WORD_W-1:0] pwdata,
    output logic [WORD_W-1:0] prdata,
    output logic              irq_o
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] ctrl_q;
    ctrl_t             ctrl;
    logic [THR_W-1:0]  thr_q;
    logic              ioff_q;
    logic              wr_en;
    logic              rd_en;
    logic              tick;
    logic              bit0;
    logic              bit1;
    logic              push;
    logic [WORD_W-1:0] word;
    logic [WARM_W-1:0] warm;
    logic [WORD_W-1:0] head;
    logic [CW-1:0]     count;
    logic              full;
    logic              empty;
    logic              pop;
    logic [7:0]        count8;

    assign wr_en  = psel && penable && pwrite;
    assign rd_en  = psel && penable && !pwrite;
    assign pop    = rd_en && (paddr == OFS_DATA);
    assign count8 = 8'(count);
    assign ctrl   = ctrl_t'({ctrl_q[27:16], ctrl_q[15:8], ctrl_q[5:4], ctrl_q[1:0]});

    // Register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            thr_q  <= THR_INIT;
            ioff_q <= 1'b0;
        end else if (wr_en) begin
            if (paddr == OFS_CTRL) ctrl_q <= pwdata & CTRL_KEEP;
            if (paddr == OFS_THR)  thr_q  <= pwdata[THR_W-1:0];
            if (paddr == OFS_IOFF) ioff_q <= pwdata[0];
        end
    end

    // Read data mux.
    always_comb begin
        prdata = '0;
        if (rd_en) begin
            case (paddr)
                OFS_CTRL: prdata = ctrl_q;
                OFS_STAT: prdata = {count8, 4'b0, warm};
                OFS_DATA: prdata = head;
                OFS_THR:  prdata = {{(WORD_W-THR_W){1'b0}}, thr_q};
                OFS_IOFF: prdata = {{(WORD_W-1){1'b0}}, ioff_q};
                default:  prdata = '0;
            endcase
        end
    end

    assign irq_o = !ioff_q && (count8 >= {3'b0, thr_q});

    rng_tick_gen #(.DW(DIV_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl.run),
        .slow_mode (ctrl.slow_sel && ctrl.slow_src),
        .div_n     (ctrl.div_n),
        .stall     (full),
        .tick_o    (tick)
    );

    rng_bit_src #(.SEED(SEED)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .dbl    (ctrl.dbl),
        .osc_a  (ctrl.osc_a),
        .osc_b  (ctrl.osc_b),
        .bit0_o (bit0),
        .bit1_o (bit1)
    );

    rng_word_pack #(.WARM_INIT(WARM_INIT)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .dbl       (ctrl.dbl),
        .bit0      (bit0),
        .bit1      (bit1),
        .warm_load (wr_en && (paddr == OFS_STAT)),
        .warm_val  (pwdata[WARM_W-1:0]),
        .warm_o    (warm),
        .push_o    (push),
        .word_o    (word)
    );

    rng_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .data_i  (word),
        .pop_i   (pop),
        .data_o  (head),
        .count_o (count),
        .full_o  (full),
        .empty_o (empty)
    );

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> (count8 == 8'(DEPTH)))
        else $error("full queue lost a word"); // R10
endmodule

// File: tb/tb_rng_periph.sv
module tb_rng_periph;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam logic [31:0] SEED = 32'h1ACE_B00C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq_o;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_s = SEED;
    bit done = 0;

    rng_periph #(.DEPTH(DEPTH), .SEED(SEED)) dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] m_step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic m_bit(input logic [31:0] s, input logic [5:0] a, input logic [5:0] b);
        return s[31] ^ s[21] ^ s[1] ^ s[0] ^ (^(~a & s[5:0])) ^ (^(~b & s[11:6]));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk);
        penable = 1;
        #1 d = prdata;
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic run_phase(input bit dbl, input bit slow, input int n, input int w,
                             input bit timing, input bit freeze, input bit irqtest);
        int p = slow ? 2 * (n + 1) : 1;
        logic [5:0] ma = 6'($urandom);
        logic [5:0] mb = 6'($urandom);
        logic [31:0] ctrl;
        logic [31:0] rd;
        int skip;
        ctrl = 32'h1 | (dbl ? 32'h2 : 0) | (slow ? 32'h30 : 0) | (32'(n) << 8)
             | (32'(ma) << 16) | (32'(mb) << 22);
        bus_wr(5'h04, 32'(w));
        bus_wr(5'h0C, 32'd1);
        bus_wr(5'h00, ctrl);
        if (timing) begin
            int first = (dbl ? (w + 1) / 2 + 16 : w + 32) * p;
            repeat (first - 1) @(negedge clk);
            check(dbl ? "R5 irq low before first word" : "R4 irq low before first word", 32'(irq_o), 0);
            @(negedge clk);
            check(w != 0 ? "R6 first word after warm-up" : "R4 first word time", 32'(irq_o), 1);
        end
        if (freeze) begin
            repeat (40) @(negedge clk);
            bus_wr(5'h00, ctrl & ~32'h1);
            bus_rd(5'h04, rd);
            check("R11 count after stop", rd[31:24], 1);
            repeat (200) @(negedge clk);
            bus_rd(5'h04, rd);
            check("R11 count frozen", rd[31:24], 1);
            bus_wr(5'h00, ctrl);
        end
        repeat (DEPTH * 32 * p + 64) @(negedge clk);
        bus_wr(5'h00, ctrl & ~32'h1);
        bus_rd(5'h04, rd);
        check("R10 queue full, R7 count", rd[31:24], DEPTH);
        check("R6 warm-up drained", {12'b0, rd[19:0]}, 0);
        if (irqtest) begin
            bus_wr(5'h0C, DEPTH);
            check("R12 irq at threshold", 32'(irq_o), 1);
            bus_wr(5'h10, 32'h1);
            check("R12 irq off bit", 32'(irq_o), 0);
            bus_wr(5'h10, 32'h0);
            bus_wr(5'h0C, DEPTH + 1);
            check("R12 irq below threshold", 32'(irq_o), 0);
            bus_wr(5'h0C, 32'd1);
        end
        skip = dbl ? 2 * ((w + 1) / 2) : w;
        for (int i = 0; i < skip; i++) m_s = m_step(m_s);
        for (int k = 0; k < DEPTH; k++) begin
            logic [31:0] exp = '0;
            for (int j = 0; j < 32; j++) begin
                exp = {exp[30:0], m_bit(m_s, ma, mb)};
                m_s = m_step(m_s);
            end
            bus_rd(5'h08, rd);
            check("R3 R8 word stream", rd, exp);
        end
        bus_rd(5'h04, rd);
        check("R8 queue drained", rd[31:24], 0);
    endtask

    initial begin
        repeat (CLK_PERIOD * 15000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 irq at reset", 32'(irq_o), 0);
        bus_rd(5'h00, rd); check("R1 control reset", rd, 0);
        bus_rd(5'h04, rd); check("R1 status reset", rd, 32'h0004_0000);
        bus_rd(5'h0C, rd); check("R1 threshold reset", rd, 4);
        bus_rd(5'h10, rd); check("R1 irq-off reset", rd, 0);
        // R2: masked readback and unmapped offset
        bus_wr(5'h00, 32'hFFFF_FFFF);
        bus_rd(5'h00, rd); check("R2 control kept bits", rd, 32'h0FFF_FF33);
        bus_wr(5'h00, 32'h0);
        bus_wr(5'h0C, 32'hFFFF_FFE7);
        bus_rd(5'h0C, rd); check("R2 threshold width", rd, 7);
        bus_wr(5'h10, 32'hFFFF_FFFE);
        bus_rd(5'h10, rd); check("R2 irq-off width", rd, 0);
        bus_rd(5'h14, rd); check("R2 unmapped offset", rd, 0);
        // R6: warm-up load field
        bus_wr(5'h04, 32'hFFF1_2345);
        bus_rd(5'h04, rd); check("R6 warm-up load", rd, 32'h0001_2345);
        // R9: empty read
        bus_rd(5'h08, rd); check("R9 empty read value", rd, 0);
        bus_rd(5'h04, rd); check("R9 empty count", rd[31:24], 0);
        // Phases: directed corners mixed with random settings
        run_phase(0, 0, 0, int'($urandom_range(0, 7)), 1, 0, 1);
        run_phase(1, 0, 0, 3, 1, 0, 0);
        run_phase(0, 1, int'($urandom_range(0, 3)), int'($urandom_range(0, 5)), 1, 0, 0);
        run_phase(1, 1, int'($urandom_range(0, 3)), int'($urandom_range(0, 9)), 1, 0, 0);
        run_phase(0, 0, 0, 0, 0, 1, 0);
        run_phase(1, 0, 0, 0, 1, 0, 0);
        bus_rd(5'h08, rd); check("R9 read after drain", rd, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule